// File: doc/BRIEF.md
# 68000 Bus Address Decoder

This block turns one 68000-family bus cycle into chip selects and read/write strobes for the memory regions of a fixed 24-bit map. It looks only at address bits 23 down to 17, the read/write line, the address strobe and the two data strobes. From these it drives active-low output-enable and write-enable lines. Every output is a combinational function of the current bus signals, so a strobe follows the bus within the same cycle. The clock and reset serve only the embedded property checks.

Five regions are byte-laned and get a separate strobe for the upper lane (data bits 15..8) and the lower lane (data bits 7..0). The upper lane is qualified by the upper data strobe and the lower lane by the lower data strobe. Three regions are word-only and get a single read strobe and a single write strobe. A region that can only be read has no write strobe at all. Any address outside the listed regions leaves every output high.

Top module: `abus_decoder`

## Requirements
- R1: A read (rw_i=1) with address in 0x000000–0x0FFFFF drives program-ROM enables rom_oe_n_o low per active lane. Bit 1 is the upper lane and bit 0 the lower lane, for every two-bit output.
- R2: Addresses 0x100000–0x1FFFFF drive work-RAM enables per lane: wram_oe_n_o on reads and wram_we_n_o on writes.
- R3: Addresses 0x200000–0x2FFFFF drive cartridge-port enables per lane: port_oe_n_o on reads and port_we_n_o on writes.
- R4: srom_oe_n_o lanes go low only on a read with address bits 23..20 equal to 4'b1100.
- R5: Addresses 0xD00000–0xDFFFFF drive backup-RAM enables per lane: sram_oe_n_o on reads and sram_we_n_o on writes.
- R6: The word-only regions each drive one strobe per direction, low when the address strobe is active and at least one data strobe is active. The regions are memory card (0x800000–0xBFFFFF, card_*), video controller (0x3C0000–0x3DFFFF, vid_*) and palette (0x400000–0x7FFFFF, pal_*).
- R7: In a byte-laned region the upper lane (bit 1) is low only while uds_n_i is low, and the lower lane (bit 0) only while lds_n_i is low.
- R8: While as_n_i is high every output is high, in the same cycle.
- R9: A write enable goes low only when rw_i is low, and an output enable only when rw_i is high. The ROM regions never drive a write strobe.
- R10: Addresses in no listed region leave every output high. These are 0x300000–0x3BFFFF, 0x3E0000–0x3FFFFF and 0xE00000–0xFFFFFF.
- R11: At most one region is selected for any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| addr_i | input | 7 | Address bits 23..17 |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_n_i | input | 1 | Address strobe, active low |
| uds_n_i | input | 1 | Upper data strobe, active low |
| lds_n_i | input | 1 | Lower data strobe, active low |
| rom_oe_n_o | output | 2 | Program ROM read enables {upper, lower} |
| wram_oe_n_o | output | 2 | Work RAM read enables |
| wram_we_n_o | output | 2 | Work RAM write enables |
| port_oe_n_o | output | 2 | Cartridge port read enables |
| port_we_n_o | output | 2 | Cartridge port write enables |
| srom_oe_n_o | output | 2 | System ROM read enables |
| sram_oe_n_o | output | 2 | Backup RAM read enables |
| sram_we_n_o | output | 2 | Backup RAM write enables |
| card_oe_n_o | output | 1 | Memory card read strobe |
| card_we_n_o | output | 1 | Memory card write strobe |
| vid_oe_n_o | output | 1 | Video controller read strobe |
| vid_we_n_o | output | 1 | Video controller write strobe |
| pal_oe_n_o | output | 1 | Palette read strobe |
| pal_we_n_o | output | 1 | Palette write strobe |

## Verification
Every output is due in the same cycle its inputs change, with no register between them. The bench applies each bus vector just after a rising edge and compares all 22 output bits with its range-based model at the following falling edge, well clear of any edge. It walks every combination of the seven address bits, direction, both data strobes and the address strobe, so each region boundary and each unmapped gap is checked in both directions and with every lane pattern.

// File: rtl/abus_pkg.sv
package abus_pkg;

  localparam int ABITS = 7;   // address bits 23..17
  localparam int NREG  = 8;

  typedef enum int {
    REG_ROM  = 0,
    REG_WRAM = 1,
    REG_PORT = 2,
    REG_VID  = 3,
    REG_PAL  = 4,
    REG_CARD = 5,
    REG_SROM = 6,
    REG_SRAM = 7
  } region_e;

  typedef struct packed {
    logic [ABITS-1:0] match;
    logic [ABITS-1:0] mask;
    logic             laned;
    logic             rd;
    logic             wr;
  } region_t;

  // index NREG-1 first in the literal
  localparam region_t [NREG-1:0] MAP = '{
    '{7'b1101000, 7'b1111000, 1'b1, 1'b1, 1'b1},  // SRAM
    '{7'b1100000, 7'b1111000, 1'b1, 1'b1, 1'b0},  // SROM
    '{7'b1000000, 7'b1100000, 1'b0, 1'b1, 1'b1},  // CARD
    '{7'b0100000, 7'b1100000, 1'b0, 1'b1, 1'b1},  // PAL
    '{7'b0011110, 7'b1111111, 1'b0, 1'b1, 1'b1},  // VID
    '{7'b0010000, 7'b1111000, 1'b1, 1'b1, 1'b1},  // PORT
    '{7'b0001000, 7'b1111000, 1'b1, 1'b1, 1'b1},  // WRAM
    '{7'b0000000, 7'b1111000, 1'b1, 1'b1, 1'b0}   // ROM
  };

endpackage

// File: rtl/abus_region_match.sv
module abus_region_match #(
  parameter int                 W     = 7,
  parameter logic [W-1:0]       MATCH = '0,
  parameter logic [W-1:0]       MASK  = '1
) (
  input  logic [W-1:0] addr_i,
  output logic         hit_o
);
  assign hit_o = ((addr_i & MASK) == MATCH);
endmodule

// File: rtl/abus_lane_strobe.sv
module abus_lane_strobe #(
  parameter bit RD_EN = 1'b1,
  parameter bit WR_EN = 1'b1
) (
  input  logic       sel_i,
  input  logic       rw_i,
  input  logic       as_n_i,
  input  logic       uds_n_i,
  input  logic       lds_n_i,
  output logic [1:0] oe_n_o,
  output logic [1:0] we_n_o
);
  logic [1:0] lane_act;

  assign lane_act = {~as_n_i & ~uds_n_i, ~as_n_i & ~lds_n_i} & {2{sel_i}};

  if (RD_EN) begin : g_rd
    assign oe_n_o = ~(lane_act & {2{rw_i}});
  end else begin : g_no_rd
    assign oe_n_o = 2'b11;
  end

  if (WR_EN) begin : g_wr
    assign we_n_o = ~(lane_act & {2{~rw_i}});
  end else begin : g_no_wr
    assign we_n_o = 2'b11;
  end
endmodule

// File: rtl/abus_word_strobe.sv
module abus_word_strobe #(
  parameter bit RD_EN = 1'b1,
  parameter bit WR_EN = 1'b1
) (
  input  logic       sel_i,
  input  logic       rw_i,
  input  logic       as_n_i,
  input  logic       uds_n_i,
  input  logic       lds_n_i,
  output logic [1:0] oe_n_o,
  output logic [1:0] we_n_o
);
  logic act;

  // lanes not distinguished: either data strobe opens the word
  assign act = sel_i & ~as_n_i & (~uds_n_i | ~lds_n_i);

  if (RD_EN) begin : g_rd
    assign oe_n_o = {2{~(act & rw_i)}};
  end else begin : g_no_rd
    assign oe_n_o = 2'b11;
  end

  if (WR_EN) begin : g_wr
    assign we_n_o = {2{~(act & ~rw_i)}};
  end else begin : g_no_wr
    assign we_n_o = 2'b11;
  end
endmodule

// File: rtl/abus_decoder.sv
module abus_decoder
  import abus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ABITS-1:0] addr_i,
  input  logic             rw_i,
  input  logic             as_n_i,
  input  logic             uds_n_i,
  input  logic             lds_n_i,
  output logic [1:0]       rom_oe_n_o,
  output logic [1:0]       wram_oe_n_o,
  output logic [1:0]       wram_we_n_o,
  output logic [1:0]       port_oe_n_o,
  output logic [1:0]       port_we_n_o,
  output logic [1:0]       srom_oe_n_o,
  output logic [1:0]       sram_oe_n_o,
  output logic [1:0]       sram_we_n_o,
  output logic             card_oe_n_o,
  output logic             card_we_n_o,
  output logic             vid_oe_n_o,
  output logic             vid_we_n_o,
  output logic             pal_oe_n_o,
  output logic             pal_we_n_o
);

  logic [NREG-1:0]       hit;
  logic [NREG-1:0][1:0]  oe_n;
  logic [NREG-1:0][1:0]  we_n;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    abus_region_match #(
      .W    (ABITS),
      .MATCH(MAP[g].match),
      .MASK (MAP[g].mask)
    ) u_match (
      .addr_i(addr_i),
      .hit_o (hit[g])
    );

    if (MAP[g].laned) begin : g_lane
      abus_lane_strobe #(
        .RD_EN(MAP[g].rd),
        .WR_EN(MAP[g].wr)
      ) u_strobe (
        .sel_i  (hit[g]),
        .rw_i   (rw_i),
        .as_n_i (as_n_i),
        .uds_n_i(uds_n_i),
        .lds_n_i(lds_n_i),
        .oe_n_o (oe_n[g]),
        .we_n_o (we_n[g])
      );
    end else begin : g_word
      abus_word_strobe #(
        .RD_EN(MAP[g].rd),
        .WR_EN(MAP[g].wr)
      ) u_strobe (
        .sel_i  (hit[g]),
        .rw_i   (rw_i),
        .as_n_i (as_n_i),
        .uds_n_i(uds_n_i),
        .lds_n_i(lds_n_i),
        .oe_n_o (oe_n[g]),
        .we_n_o (we_n[g])
      );
    end
  end

  assign rom_oe_n_o  = oe_n[REG_ROM];
  assign wram_oe_n_o = oe_n[REG_WRAM];
  assign wram_we_n_o = we_n[REG_WRAM];
  assign port_oe_n_o = oe_n[REG_PORT];
  assign port_we_n_o = we_n[REG_PORT];
  assign srom_oe_n_o = oe_n[REG_SROM];
  assign sram_oe_n_o = oe_n[REG_SRAM];
  assign sram_we_n_o = we_n[REG_SRAM];
  assign card_oe_n_o = &oe_n[REG_CARD];
  assign card_we_n_o = &we_n[REG_CARD];
  assign vid_oe_n_o  = &oe_n[REG_VID];
  assign vid_we_n_o  = &we_n[REG_VID];
  assign pal_oe_n_o  = &oe_n[REG_PAL];
  assign pal_we_n_o  = &we_n[REG_PAL];

  // Flattened views for the checks below
  logic any_oe_low, any_we_low;
  logic [1:0] laned_upper_low, laned_lower_low;
  assign any_oe_low = ~&oe_n;
  assign any_we_low = ~&we_n;
  assign laned_upper_low = {~rom_oe_n_o[1] | ~wram_oe_n_o[1] | ~port_oe_n_o[1] |
                            ~srom_oe_n_o[1] | ~sram_oe_n_o[1],
                            ~wram_we_n_o[1] | ~port_we_n_o[1] | ~sram_we_n_o[1]};
  assign laned_lower_low = {~rom_oe_n_o[0] | ~wram_oe_n_o[0] | ~port_oe_n_o[0] |
                            ~srom_oe_n_o[0] | ~sram_oe_n_o[0],
                            ~wram_we_n_o[0] | ~port_we_n_o[0] | ~sram_we_n_o[0]};

  p_idle_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_n_i |-> (!any_oe_low && !any_we_low));

  p_oe_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_oe_low |-> rw_i);

  p_we_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_we_low |-> !rw_i);

  p_rom_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_n[REG_ROM] == 2'b11) && (we_n[REG_SROM] == 2'b11));

  p_upper_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|laned_upper_low) |-> !uds_n_i);

  p_lower_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|laned_lower_low) |-> !lds_n_i);

  p_srom_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srom_oe_n_o != 2'b11) |-> (addr_i[6:3] == 4'b1100 && rw_i));

  p_one_region_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

  p_gap_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[6:3] == 4'b0011 && addr_i[2:0] != 3'b110) || (addr_i[6:4] == 3'b111)
    |-> (!any_oe_low && !any_we_low));

  p_word_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_oe_n_o || !card_we_n_o || !vid_oe_n_o || !vid_we_n_o ||
     !pal_oe_n_o || !pal_we_n_o) |-> (!uds_n_i || !lds_n_i));

endmodule

// File: tb/abus_decoder_test.sv
module abus_decoder_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] addr_i = '0;
  logic       rw_i = 1'b1;
  logic       as_n_i = 1'b1;
  logic       uds_n_i = 1'b1;
  logic       lds_n_i = 1'b1;

  logic [1:0] rom_oe_n_o, wram_oe_n_o, wram_we_n_o, port_oe_n_o, port_we_n_o;
  logic [1:0] srom_oe_n_o, sram_oe_n_o, sram_we_n_o;
  logic card_oe_n_o, card_we_n_o, vid_oe_n_o, vid_we_n_o, pal_oe_n_o, pal_we_n_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  abus_decoder uut (
    .clk_i, .rst_ni, .addr_i, .rw_i, .as_n_i, .uds_n_i, .lds_n_i,
    .rom_oe_n_o, .wram_oe_n_o, .wram_we_n_o, .port_oe_n_o, .port_we_n_o,
    .srom_oe_n_o, .sram_oe_n_o, .sram_we_n_o,
    .card_oe_n_o, .card_we_n_o, .vid_oe_n_o, .vid_we_n_o, .pal_oe_n_o, .pal_we_n_o
  );

  function automatic logic [21:0] actual();
    return {rom_oe_n_o, wram_oe_n_o, wram_we_n_o, port_oe_n_o, port_we_n_o,
            srom_oe_n_o, sram_oe_n_o, sram_we_n_o,
            card_oe_n_o, card_we_n_o, vid_oe_n_o, vid_we_n_o, pal_oe_n_o, pal_we_n_o};
  endfunction

  // Behavioural model from address ranges
  function automatic logic [21:0] model(input logic [6:0] a, input logic rw,
                                        input logic as_n, input logic uds_n,
                                        input logic lds_n);
    int unsigned base;
    bit up, lo, any, rd, wr;
    bit [1:0] ln;
    bit [1:0] r_rom, r_wo, r_ww, r_po, r_pw, r_so, r_bo, r_bw;
    bit c_o, c_w, v_o, v_w, p_o, p_w;
    base = int'(a) << 17;
    up = !as_n && !uds_n;   // R7 upper lane
    lo = !as_n && !lds_n;   // R7 lower lane
    any = up || lo;
    rd = rw; wr = !rw;      // R9 direction
    ln = {up, lo};
    r_rom = 0; r_wo = 0; r_ww = 0; r_po = 0; r_pw = 0; r_so = 0; r_bo = 0; r_bw = 0;
    c_o = 0; c_w = 0; v_o = 0; v_w = 0; p_o = 0; p_w = 0;
    if (base < 32'h100000)                              r_rom = rd ? ln : 2'b00;
    else if (base < 32'h200000) begin r_wo = rd ? ln : 2'b00; r_ww = wr ? ln : 2'b00; end
    else if (base < 32'h300000) begin r_po = rd ? ln : 2'b00; r_pw = wr ? ln : 2'b00; end
    else if (base >= 32'h3C0000 && base < 32'h3E0000) begin v_o = any && rd; v_w = any && wr; end
    else if (base >= 32'h400000 && base < 32'h800000) begin p_o = any && rd; p_w = any && wr; end
    else if (base >= 32'h800000 && base < 32'hC00000) begin c_o = any && rd; c_w = any && wr; end
    else if (base >= 32'hC00000 && base < 32'hD00000)   r_so = rd ? ln : 2'b00;
    else if (base >= 32'hD00000 && base < 32'hE00000) begin r_bo = rd ? ln : 2'b00; r_bw = wr ? ln : 2'b00; end
    return ~{r_rom, r_wo, r_ww, r_po, r_pw, r_so, r_bo, r_bw, c_o, c_w, v_o, v_w, p_o, p_w};
  endfunction

  function automatic string tag_of(input logic [6:0] a, input logic as_n);
    int unsigned base;
    base = int'(a) << 17;
    if (as_n) return "R8";
    if (base < 32'h100000) return "R1";
    if (base < 32'h200000) return "R2";
    if (base < 32'h300000) return "R3";
    if (base >= 32'h3C0000 && base < 32'h3E0000) return "R6";
    if (base >= 32'h400000 && base < 32'hC00000) return "R6";
    if (base >= 32'hC00000 && base < 32'hD00000) return "R4";
    if (base >= 32'hD00000 && base < 32'hE00000) return "R5";
    return "R10";
  endfunction

  task automatic check(input string tag);
    logic [21:0] exp_v, act_v;
    exp_v = model(addr_i, rw_i, as_n_i, uds_n_i, lds_n_i);
    act_v = actual();
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s (lanes R7, direction R9, exclusivity R11) addr=%h rw=%b as=%b uds=%b lds=%b act=%b exp=%b",
               tag, addr_i, rw_i, as_n_i, uds_n_i, lds_n_i, act_v, exp_v);
    end
  endtask

  initial begin
    // reset state: bus idle, nothing selected (R8)
    #1;
    @(negedge clk_i);
    check("R8");
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // exhaustive walk: addr, rw, uds, lds, as
    for (int i = 0; i < 2048; i++) begin
      @(posedge clk_i);
      #1;
      addr_i  = i[6:0];
      rw_i    = i[7];
      uds_n_i = i[8];
      lds_n_i = i[9];
      as_n_i  = i[10];
      @(negedge clk_i);
      check(tag_of(addr_i, as_n_i));
    end
    // R8: strobe release in the same cycle on an active work-RAM write
    @(posedge clk_i); #1;
    addr_i = 7'b0001010; rw_i = 1'b0; uds_n_i = 1'b0; lds_n_i = 1'b0; as_n_i = 1'b0;
    @(negedge clk_i); check("R2");
    @(posedge clk_i); #1 as_n_i = 1'b1;
    @(negedge clk_i); check("R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule